// File: doc/BRIEF.md
# Single-Assignment Tagged Memory with Deferred Reads

This block is a small write-once memory. Each element carries a presence flag. A write puts a value into an empty element and marks it present. A read request names an element and carries a requester tag. If the element is present, the answer goes out at once. If it is absent, the request is not refused and does not stall. The requester tag is parked inside the block, and the block answers it by itself as soon as the element is written.

Parked requests live in a fixed pool of entries shared by all elements. The entries for one element are chained in arrival order. When a write fills an element that has parked readers, those readers are answered one per cycle, in arrival order, on a valid/ready response port. While that drain is running, new writes, reads and clears wait.

A range-clear command returns a span of elements to the absent state and throws away any parked requests against them. A second write to an element that is already present is dropped, and an error pulse is raised.

Top module: `istr_mem`

## Requirements
- R1: After reset no element is present, `resp_valid` and `wr_err` are low, and `wr_ready` and `rd_ready` are high.
- R2: A write to an absent element stores the data. A later read of that element produces, in the cycle after the read is accepted, a response carrying the read's tag and the stored data.
- R3: A read of an absent element produces no response until that element is written. It is then answered with the written data and its own tag.
- R4: Several parked reads of one element are all answered with the written value, in the order the reads were accepted, one per cycle while `resp_ready` is high.
- R5: A write to an element that is already present leaves the stored value unchanged and raises `wr_err` for exactly the one cycle after the write is accepted.
- R6: While every pool entry holds a parked read, `rd_ready` is low.
- R7: While parked responses are draining, `wr_ready`, `rd_ready` and `clr_ready` are low.
- R8: A clear over `clr_lo..clr_hi` (both ends included) marks those elements absent and discards their parked reads, so no response is ever produced for them. Elements outside the range keep their contents.
- R9: While `resp_valid` is high and `resp_ready` is low, the response and its tag and data hold steady.
- R10: A pending clear blocks writes and reads, and a pending write blocks reads. So in a given cycle `rd_ready` is low whenever `wr_valid` or `clr_valid` is high, and `wr_ready` is low whenever `clr_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_valid | input | 1 | Range-clear request |
| clr_ready | output | 1 | Clear accepted when high with `clr_valid` |
| clr_lo | input | IW | First element to clear |
| clr_hi | input | IW | Last element to clear |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Write accepted when high with `wr_valid` |
| wr_idx | input | IW | Element to write |
| wr_data | input | DW | Write data |
| wr_err | output | 1 | One-cycle pulse after a write to a present element |
| rd_valid | input | 1 | Read request |
| rd_ready | output | 1 | Read accepted when high with `rd_valid` |
| rd_idx | input | IW | Element to read |
| rd_tag | input | TW | Requester tag |
| resp_valid | output | 1 | Response available |
| resp_ready | input | 1 | Consumer takes the response |
| resp_tag | output | TW | Tag of the answered request |
| resp_data | output | DW | Value of the element |

## Verification
The assertions assume the index inputs stay below the element count and that `clr_lo` is no greater than `clr_hi`. They also assume the consumer does not change `resp_ready` between sampling and the clock edge. The bench drives only valid indices and ordered ranges on an eight-element, four-entry configuration, and changes inputs just after each rising edge. It sweeps every element through a parked read, the write that answers it, and a read that hits directly. It then fills the pool, stalls the consumer during a drain, and clears ranges both inside and outside of parked reads.

// File: rtl/istr_pkg.sv
package istr_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_CLEAR = 2'd1,
    OP_WRITE = 2'd2,
    OP_READ  = 2'd3
  } istr_op_e;
endpackage

// File: rtl/istr_elems.sv
module istr_elems #(
  parameter int N_ELEM = 8,
  parameter int DW     = 8,
  parameter int PW     = 2,
  localparam int IW    = $clog2(N_ELEM)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_en,
  input  logic [IW-1:0] clr_lo,
  input  logic [IW-1:0] clr_hi,
  input  logic          st_en,
  input  logic [IW-1:0] st_idx,
  input  logic [DW-1:0] st_data,
  input  logic          app_en,
  input  logic [IW-1:0] app_idx,
  input  logic [PW-1:0] app_ptr,
  input  logic [IW-1:0] a_idx,
  output logic          a_full,
  output logic          a_has,
  output logic [PW-1:0] a_head,
  output logic [PW-1:0] a_tail,
  input  logic [IW-1:0] b_idx,
  output logic          b_full,
  output logic          b_has,
  output logic [PW-1:0] b_tail,
  output logic [DW-1:0] b_data,
  input  logic [IW-1:0] d_idx,
  output logic [DW-1:0] d_data
);
  logic [N_ELEM-1:0] full_q, full_d, has_q, has_d;
  logic [PW-1:0]     head_q [N_ELEM];
  logic [PW-1:0]     head_d [N_ELEM];
  logic [PW-1:0]     tail_q [N_ELEM];
  logic [PW-1:0]     tail_d [N_ELEM];
  logic [DW-1:0]     mem_q  [N_ELEM];

  always_comb begin
    full_d = full_q;
    has_d  = has_q;
    head_d = head_q;
    tail_d = tail_q;
    for (int i = 0; i < N_ELEM; i++) begin
      if (clr_en && (IW'(i) >= clr_lo) && (IW'(i) <= clr_hi)) begin
        full_d[i] = 1'b0;
        has_d[i]  = 1'b0;
      end
    end
    if (st_en) begin
      full_d[st_idx] = 1'b1;
      has_d[st_idx]  = 1'b0;
    end
    if (app_en) begin
      tail_d[app_idx] = app_ptr;
      if (!has_q[app_idx]) begin
        head_d[app_idx] = app_ptr;
        has_d[app_idx]  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= '0;
      has_q  <= '0;
      for (int i = 0; i < N_ELEM; i++) begin
        head_q[i] <= '0;
        tail_q[i] <= '0;
      end
    end else begin
      full_q <= full_d;
      has_q  <= has_d;
      head_q <= head_d;
      tail_q <= tail_d;
    end
  end

  always_ff @(posedge clk) begin
    if (st_en) mem_q[st_idx] <= st_data;
  end

  assign a_full = full_q[a_idx];
  assign a_has  = has_q[a_idx];
  assign a_head = head_q[a_idx];
  assign a_tail = tail_q[a_idx];
  assign b_full = full_q[b_idx];
  assign b_has  = has_q[b_idx];
  assign b_tail = tail_q[b_idx];
  assign b_data = mem_q[b_idx];
  assign d_data = mem_q[d_idx];

  // R2
  store_sets_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_en && !clr_en |=> full_q[$past(st_idx)]);

  // R3
  no_park_on_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    app_en |-> !full_q[app_idx]);
endmodule

// File: rtl/istr_pool.sv
module istr_pool #(
  parameter int N_POOL = 4,
  parameter int TW     = 4,
  parameter int IW     = 3,
  localparam int PW    = $clog2(N_POOL)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_en,
  input  logic [TW-1:0] alloc_tag,
  input  logic [IW-1:0] alloc_elem,
  output logic [PW-1:0] alloc_ptr,
  output logic          pool_full,
  input  logic          link_en,
  input  logic [PW-1:0] link_from,
  input  logic          rel_en,
  input  logic [PW-1:0] rel_ptr,
  output logic [TW-1:0] rel_tag,
  output logic [PW-1:0] rel_next,
  input  logic          clr_en,
  input  logic [IW-1:0] clr_lo,
  input  logic [IW-1:0] clr_hi
);
  logic [N_POOL-1:0] used_q, used_d;
  logic [TW-1:0]     tag_q  [N_POOL];
  logic [PW-1:0]     next_q [N_POOL];
  logic [IW-1:0]     elem_q [N_POOL];

  always_comb begin
    alloc_ptr = '0;
    for (int e = N_POOL - 1; e >= 0; e--) begin
      if (!used_q[e]) alloc_ptr = PW'(e);
    end
  end
  assign pool_full = &used_q;

  always_comb begin
    used_d = used_q;
    for (int e = 0; e < N_POOL; e++) begin
      if (clr_en && (elem_q[e] >= clr_lo) && (elem_q[e] <= clr_hi)) used_d[e] = 1'b0;
    end
    if (rel_en)   used_d[rel_ptr]   = 1'b0;
    if (alloc_en) used_d[alloc_ptr] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) used_q <= '0;
    else        used_q <= used_d;
  end

  always_ff @(posedge clk) begin
    if (alloc_en) begin
      tag_q[alloc_ptr]  <= alloc_tag;
      elem_q[alloc_ptr] <= alloc_elem;
    end
    if (link_en) next_q[link_from] <= alloc_ptr;
  end

  assign rel_tag  = tag_q[rel_ptr];
  assign rel_next = next_q[rel_ptr];

  // R6
  no_alloc_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> !pool_full);

  // R4
  release_live_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel_en |-> used_q[rel_ptr]);
endmodule

// File: rtl/istr_mem.sv
module istr_mem #(
  parameter int N_ELEM = 8,
  parameter int DW     = 8,
  parameter int TW     = 4,
  parameter int N_POOL = 4,
  localparam int IW    = $clog2(N_ELEM),
  localparam int PW    = $clog2(N_POOL)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_valid,
  output logic          clr_ready,
  input  logic [IW-1:0] clr_lo,
  input  logic [IW-1:0] clr_hi,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  output logic          wr_err,
  input  logic          rd_valid,
  output logic          rd_ready,
  input  logic [IW-1:0] rd_idx,
  input  logic [TW-1:0] rd_tag,
  output logic          resp_valid,
  input  logic          resp_ready,
  output logic [TW-1:0] resp_tag,
  output logic [DW-1:0] resp_data
);
  import istr_pkg::*;

  logic          a_full, a_has, b_full, b_has;
  logic [PW-1:0] a_head, a_tail, b_tail;
  logic [DW-1:0] b_data, d_data;
  logic [PW-1:0] alloc_ptr, rel_next;
  logic [TW-1:0] rel_tag;
  logic          pool_full;

  logic          drn_q, drn_d;
  logic [PW-1:0] drn_ptr_q, drn_ptr_d, drn_last_q, drn_last_d;
  logic [IW-1:0] drn_idx_q, drn_idx_d;
  logic          rv_q, rv_d, err_q, err_d;
  logic [TW-1:0] rt_q, rt_d;
  logic [DW-1:0] rdat_q, rdat_d;

  istr_op_e op;
  logic slot_free, hit_load, miss_park, st_en, wr_rej, drn_load;

  assign slot_free = !rv_q || resp_ready;
  assign clr_ready = !drn_q;
  assign wr_ready  = !drn_q && !clr_valid;
  assign rd_ready  = !drn_q && !clr_valid && !wr_valid && !pool_full && slot_free;

  always_comb begin
    op = OP_IDLE;
    if (clr_valid && clr_ready)      op = OP_CLEAR;
    else if (wr_valid && wr_ready)   op = OP_WRITE;
    else if (rd_valid && rd_ready)   op = OP_READ;
  end

  assign st_en     = (op == OP_WRITE) && !a_full;
  assign wr_rej    = (op == OP_WRITE) && a_full;
  assign hit_load  = (op == OP_READ) && b_full;
  assign miss_park = (op == OP_READ) && !b_full;
  assign drn_load  = drn_q && slot_free;

  istr_elems #(.N_ELEM(N_ELEM), .DW(DW), .PW(PW)) u_elems (
    .clk(clk), .rst_n(rst_n),
    .clr_en(op == OP_CLEAR), .clr_lo(clr_lo), .clr_hi(clr_hi),
    .st_en(st_en), .st_idx(wr_idx), .st_data(wr_data),
    .app_en(miss_park), .app_idx(rd_idx), .app_ptr(alloc_ptr),
    .a_idx(wr_idx), .a_full(a_full), .a_has(a_has), .a_head(a_head), .a_tail(a_tail),
    .b_idx(rd_idx), .b_full(b_full), .b_has(b_has), .b_tail(b_tail), .b_data(b_data),
    .d_idx(drn_idx_q), .d_data(d_data)
  );

  istr_pool #(.N_POOL(N_POOL), .TW(TW), .IW(IW)) u_pool (
    .clk(clk), .rst_n(rst_n),
    .alloc_en(miss_park), .alloc_tag(rd_tag), .alloc_elem(rd_idx),
    .alloc_ptr(alloc_ptr), .pool_full(pool_full),
    .link_en(miss_park && b_has), .link_from(b_tail),
    .rel_en(drn_load), .rel_ptr(drn_ptr_q), .rel_tag(rel_tag), .rel_next(rel_next),
    .clr_en(op == OP_CLEAR), .clr_lo(clr_lo), .clr_hi(clr_hi)
  );

  always_comb begin
    drn_d      = drn_q;
    drn_ptr_d  = drn_ptr_q;
    drn_last_d = drn_last_q;
    drn_idx_d  = drn_idx_q;
    rv_d       = rv_q;
    rt_d       = rt_q;
    rdat_d     = rdat_q;
    err_d      = wr_rej;
    if (st_en && a_has) begin
      drn_d      = 1'b1;
      drn_ptr_d  = a_head;
      drn_last_d = a_tail;
      drn_idx_d  = wr_idx;
    end
    if (hit_load) begin
      rv_d   = 1'b1;
      rt_d   = rd_tag;
      rdat_d = b_data;
    end else if (drn_load) begin
      rv_d      = 1'b1;
      rt_d      = rel_tag;
      rdat_d    = d_data;
      drn_ptr_d = rel_next;
      if (drn_ptr_q == drn_last_q) drn_d = 1'b0;
    end else if (resp_ready) begin
      rv_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drn_q      <= 1'b0;
      drn_ptr_q  <= '0;
      drn_last_q <= '0;
      drn_idx_q  <= '0;
      rv_q       <= 1'b0;
      rt_q       <= '0;
      rdat_q     <= '0;
      err_q      <= 1'b0;
    end else begin
      drn_q      <= drn_d;
      drn_ptr_q  <= drn_ptr_d;
      drn_last_q <= drn_last_d;
      drn_idx_q  <= drn_idx_d;
      rv_q       <= rv_d;
      rt_q       <= rt_d;
      rdat_q     <= rdat_d;
      err_q      <= err_d;
    end
  end

  assign resp_valid = rv_q;
  assign resp_tag   = rt_q;
  assign resp_data  = rdat_q;
  assign wr_err     = err_q;

  // R9
  resp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_ready |=> resp_valid && $stable(resp_tag) && $stable(resp_data));

  // R5
  dup_write_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_ready && a_full |=> wr_err);

  // R2
  hit_answers_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_ready && b_full |=> resp_valid && (resp_tag == $past(rd_tag)));

  // R7
  drain_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drn_q) |-> $past(wr_valid && wr_ready));

  // R4
  one_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hit_load, drn_load}));
endmodule

// File: tb/tb_istr_mem.sv
module tb_istr_mem;
  localparam int CLK_PERIOD = 10;
  localparam int NE = 8;
  localparam int IW = 3;
  localparam int DW = 8;
  localparam int TW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr_valid = 1'b0, clr_ready;
  logic [IW-1:0] clr_lo = '0, clr_hi = '0;
  logic wr_valid = 1'b0, wr_ready, wr_err;
  logic [IW-1:0] wr_idx = '0;
  logic [DW-1:0] wr_data = '0;
  logic rd_valid = 1'b0, rd_ready;
  logic [IW-1:0] rd_idx = '0;
  logic [TW-1:0] rd_tag = '0;
  logic resp_valid, resp_ready = 1'b1;
  logic [TW-1:0] resp_tag;
  logic [DW-1:0] resp_data;

  int n_chk = 0, n_err = 0;
  int rn = 0;
  int got_tag [256];
  int got_dat [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  istr_mem dut (
    .clk(clk), .rst_n(rst_n),
    .clr_valid(clr_valid), .clr_ready(clr_ready), .clr_lo(clr_lo), .clr_hi(clr_hi),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_idx(wr_idx), .wr_data(wr_data), .wr_err(wr_err),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_idx(rd_idx), .rd_tag(rd_tag),
    .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_tag(resp_tag), .resp_data(resp_data)
  );

  always @(negedge clk) begin
    if (rst_n && resp_valid && resp_ready && rn < 256) begin
      got_tag[rn] = int'(resp_tag);
      got_dat[rn] = int'(resp_data);
      rn = rn + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_wr(input int i, input int d);
    wr_idx = IW'(i); wr_data = DW'(d); wr_valid = 1'b1;
    #1;
    while (!wr_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    wr_valid = 1'b0;
  endtask

  task automatic do_rd(input int i, input int t);
    rd_idx = IW'(i); rd_tag = TW'(t); rd_valid = 1'b1;
    #1;
    while (!rd_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    rd_valid = 1'b0;
  endtask

  task automatic do_clr(input int lo, input int hi);
    clr_lo = IW'(lo); clr_hi = IW'(hi); clr_valid = 1'b1;
    #1;
    while (!clr_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    clr_valid = 1'b0;
  endtask

  task automatic exp_resp(input int k, input int t, input int d, input string req);
    chk(rn > k, req, rn, k + 1);
    if (rn > k) begin
      chk(got_tag[k] == t, req, got_tag[k], t);
      chk(got_dat[k] == d, req, got_dat[k], d);
    end
  endtask

  function automatic int val_of(input int i);
    return (i * 37 + 5) % 256;
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    n_err++; n_chk++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int base;
    int held_tag;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    chk(!resp_valid, "R1", resp_valid, 0);
    chk(!wr_err, "R1", wr_err, 0);
    chk(wr_ready && rd_ready, "R1", {wr_ready, rd_ready}, 3);

    // R1 R2 R3 sweep: every element parks a read, gets written, then hits directly
    for (int i = 0; i < NE; i++) begin
      base = rn;
      do_rd(i, i);
      idle(3);
      chk(rn == base, "R3", rn, base);
      do_wr(i, val_of(i));
      idle(3);
      exp_resp(base, i, val_of(i), "R3");
      do_rd(i, 8 + i);
      idle(2);
      exp_resp(base + 1, 8 + i, val_of(i), "R2");
    end

    // R8 clear everything; fill pool with parked reads
    do_clr(0, NE - 1);
    base = rn;
    do_rd(3, 10); do_rd(3, 11); do_rd(3, 12); do_rd(5, 13);
    idle(2);
    chk(rn == base, "R8", rn, base);
    // R6 pool full blocks reads
    rd_idx = 3'd0; rd_tag = 4'd0; rd_valid = 1'b1;
    #1;
    chk(!rd_ready, "R6", rd_ready, 0);
    rd_valid = 1'b0;
    idle(1);

    // R9 R7 R4 drain with a stalled consumer
    resp_ready = 1'b0;
    do_wr(3, 8'h5A);
    idle(1);
    chk(resp_valid, "R9", resp_valid, 1);
    held_tag = int'(resp_tag);
    chk(held_tag == 10, "R4", held_tag, 10);
    chk(!wr_ready && !rd_ready && !clr_ready, "R7", {wr_ready, rd_ready, clr_ready}, 0);
    idle(3);
    chk(resp_valid && int'(resp_tag) == held_tag && resp_data == 8'h5A, "R9", int'(resp_tag), held_tag);
    resp_ready = 1'b1;
    idle(6);
    exp_resp(base, 10, 8'h5A, "R4");
    exp_resp(base + 1, 11, 8'h5A, "R4");
    exp_resp(base + 2, 12, 8'h5A, "R4");
    chk(rn == base + 3, "R4", rn, base + 3);
    chk(wr_ready && clr_ready, "R7", {wr_ready, clr_ready}, 3);
    do_wr(5, 8'h77);
    idle(3);
    exp_resp(base + 3, 13, 8'h77, "R3");

    // R5 duplicate write
    do_wr(3, 8'h11);
    chk(wr_err, "R5", wr_err, 1);
    idle(1);
    chk(!wr_err, "R5", wr_err, 0);
    base = rn;
    do_rd(3, 5);
    idle(2);
    exp_resp(base, 5, 8'h5A, "R5");

    // R10 arbitration between pending commands
    wr_valid = 1'b1; rd_valid = 1'b1; wr_idx = 3'd0; rd_idx = 3'd0;
    #1;
    chk(!rd_ready, "R10", rd_ready, 0);
    chk(wr_ready, "R10", wr_ready, 1);
    clr_valid = 1'b1;
    #1;
    chk(!wr_ready && !rd_ready, "R10", {wr_ready, rd_ready}, 0);
    wr_valid = 1'b0; rd_valid = 1'b0; clr_valid = 1'b0;
    idle(1);

    // R8 partial clear
    do_clr(0, NE - 1);
    do_wr(2, 8'h22);
    do_wr(7, 8'h27);
    do_rd(6, 7);
    do_rd(4, 9);
    do_clr(4, 6);
    base = rn;
    do_rd(2, 1);
    idle(2);
    exp_resp(base, 1, 8'h22, "R8");
    do_rd(7, 3);
    idle(2);
    exp_resp(base + 1, 3, 8'h27, "R8");
    do_rd(4, 2);
    do_wr(6, 8'h66);
    idle(4);
    chk(rn == base + 2, "R8", rn, base + 2);
    do_wr(4, 8'h44);
    idle(4);
    exp_resp(base + 2, 2, 8'h44, "R8");
    chk(rn == base + 3, "R8", rn, base + 3);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule